// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a register-mapped mailbox that lets a host processor hand commands to an embedded controller. The host uses a 32-bit register bus. One write of a packed command word starts a transaction. Before that write, the host may load up to sixteen bytes of outgoing data into a write buffer. The host then polls a status word until its busy bit drops. The status word also reports an error flag, an error code, the id of the responder and the sub-id of the command that finished. The host may fetch up to sixteen bytes of returned data, either as 32-bit words or as single bytes.

On the controller side, each accepted command produces a one-cycle announcement pulse, and the decoded command fields stay latched. The controller reads the write buffer by word index and fills the read buffer by word index. It ends the transaction with a completion strobe that carries the error flag, the error code and its own id. When the command asked for it, completion also sends a one-cycle interrupt pulse back to the host. The host may try to issue a command while one is still outstanding. That write is refused and leaves a sticky overrun indication for the controller.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, busy, overrun, both interrupt outputs and every status field read as zero, and both data buffers hold zero.
- R2: A host write to offset 0x00 while not busy latches opcode bits [7:0], the completion-interrupt flag from bit 8, the sub-id from bits [15:12] and the size from bits [23:16]. Bits [11:9] and [31:24] are ignored. In the cycle after the write edge, the controller pulse is high for exactly one cycle and busy is set.
- R3: A host write to offset 0x00 while busy leaves the latched fields unchanged and produces no controller pulse. It sets an overrun flag that stays set until reset.
- R4: A completion strobe while busy clears busy. In the same edge it loads the status fields. A host read of offset 0x00 returns busy in bit 0, error in bit 1, the completed sub-id in bits [7:4], the initiator id in bits [15:8] and the error code in bits [23:16]. All other bits read zero.
- R5: Completion raises the host interrupt for exactly one cycle, together with the fall of busy, and only when the completed command had its bit 8 set.
- R6: A completion strobe while not busy changes no status field and raises no host interrupt.
- R7: Host 32-bit writes to offsets 0x80 to 0x8F fill write-buffer word (offset bits [3:2]), which the controller reads by index. Host reads of this range return zero.
- R8: The controller writes read-buffer words by index. A host word read of offsets 0x90 to 0x9F returns word (offset bits [3:2]). A byte read returns byte lane (offset bits [1:0]) of that word, with lane 0 being bits [7:0], zero-extended.
- R9: Host writes to offsets 0x90 to 0x9F leave the read buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe; data appears on h_rdata after the edge |
| h_byte | input | 1 | Host read width: 1 selects a single byte, 0 a 32-bit word |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_irq | output | 1 | One-cycle completion interrupt to the host |
| c_cmd_irq | output | 1 | One-cycle new-command pulse to the controller |
| c_opcode | output | 8 | Latched opcode |
| c_ioc | output | 1 | Latched completion-interrupt request |
| c_sub | output | 4 | Latched command sub-id |
| c_size | output | 8 | Latched data size |
| c_busy | output | 1 | Transaction outstanding |
| c_overrun | output | 1 | Sticky: host issued a command while busy |
| c_wbuf_idx | input | 2 | Write-buffer word index for the controller read |
| c_wbuf_data | output | 32 | Write-buffer word at c_wbuf_idx |
| c_rbuf_we | input | 1 | Read-buffer word write enable |
| c_rbuf_idx | input | 2 | Read-buffer word index |
| c_rbuf_data | input | 32 | Read-buffer write data |
| c_done | input | 1 | Completion strobe |
| c_err | input | 1 | Error flag posted with completion |
| c_err_code | input | 8 | Error code posted with completion |
| c_initiator | input | 8 | Responder id posted with completion |

## Verification
The hardest cases to reach from the ports are the races around the busy window. One is a second command that arrives while the first is still outstanding. Another is a completion strobe that arrives when nothing is outstanding. The stimulus reaches both on purpose. It issues a command and, while withholding the completion, writes a different command word. It then checks that the latched fields did not change, that no pulse appeared and that the overrun flag is set. After a completion, it asserts the strobe again with different error fields and reads the status back to show that nothing moved. It also uses command words with the reserved bits set and with the interrupt flag both set and clear, so that the field slicing and the conditional host interrupt are checked.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  // Packed command word, bit 0 at the right
  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] sub;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] opcode;
  } cmd_word_t;

  // Packed status word, bit 0 at the right
  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] code;
    logic [7:0] initiator;
    logic [3:0] sub;
    logic [1:0] rsv_lo;
    logic       err;
    logic       busy;
  } stat_word_t;

endpackage

// File: rtl/ipc_word_buf.sv
module ipc_word_buf #(
  parameter int NWORDS = 4,
  parameter int WW     = 32,
  localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [WW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic en;
    assign en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (en) begin
        mem_q[g] <= wdata;
      end
    end
  end

  assign rdata = mem_q[ridx];

endmodule

// File: rtl/ipc_cmd_ctrl.sv
module ipc_cmd_ctrl
  import ipc_mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic       done,
  input  logic       done_err,
  input  logic [7:0] done_code,
  input  logic [7:0] done_init,
  output cmd_word_t  cmd_q,
  output logic       cmd_pulse,
  output logic       busy,
  output logic       cpl_irq,
  output logic       overrun,
  output stat_word_t status
);

  logic       busy_q, busy_d;
  logic       ovr_q, ovr_d;
  logic       pulse_q, irq_q, irq_d;
  logic       err_q;
  logic [7:0] code_q, init_q;
  logic [3:0] sub_q;
  cmd_word_t  cmd_r;
  logic       accept, finish;

  // next-state logic
  always_comb begin
    accept = cmd_wr && !busy_q;
    finish = done && busy_q;
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    ovr_d = ovr_q || (cmd_wr && busy_q);
    irq_d = finish && cmd_r.ioc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
      cmd_r   <= '0;
      err_q   <= 1'b0;
      code_q  <= '0;
      init_q  <= '0;
      sub_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      ovr_q   <= ovr_d;
      pulse_q <= accept;
      irq_q   <= irq_d;
      if (accept) begin
        cmd_r <= cmd_word_t'(cmd_wdata);
      end
      if (finish) begin
        err_q  <= done_err;
        code_q <= done_code;
        init_q <= done_init;
        sub_q  <= cmd_r.sub;
      end
    end
  end

  always_comb begin
    status           = '0;
    status.busy      = busy_q;
    status.err       = err_q;
    status.sub       = sub_q;
    status.initiator = init_q;
    status.code      = code_q;
  end

  assign cmd_q     = cmd_r;
  assign cmd_pulse = pulse_q;
  assign busy      = busy_q;
  assign cpl_irq   = irq_q;
  assign overrun   = ovr_q;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_BYTES = 16,
  parameter int WBUF_BASE = 'h80,
  parameter int RBUF_BASE = 'h90,
  localparam int NW       = BUF_BYTES / 4,
  localparam int OFS_W    = $clog2(BUF_BYTES),
  localparam int IW       = OFS_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic              h_byte,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              c_cmd_irq,
  output logic [7:0]        c_opcode,
  output logic              c_ioc,
  output logic [3:0]        c_sub,
  output logic [7:0]        c_size,
  output logic              c_busy,
  output logic              c_overrun,
  input  logic [IW-1:0]     c_wbuf_idx,
  output logic [31:0]       c_wbuf_data,
  input  logic              c_rbuf_we,
  input  logic [IW-1:0]     c_rbuf_idx,
  input  logic [31:0]       c_rbuf_data,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [7:0]        c_err_code,
  input  logic [7:0]        c_initiator
);

  localparam logic [ADDR_W-1:0] WB = ADDR_W'(WBUF_BASE);
  localparam logic [ADDR_W-1:0] RB = ADDR_W'(RBUF_BASE);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  // address decode
  logic hit_cmd, hit_wbuf, hit_rbuf;
  logic [IW-1:0] h_idx;
  always_comb begin
    hit_cmd  = (h_addr == '0);
    hit_wbuf = (h_addr[ADDR_W-1:OFS_W] == WB[ADDR_W-1:OFS_W]);
    hit_rbuf = (h_addr[ADDR_W-1:OFS_W] == RB[ADDR_W-1:OFS_W]);
    h_idx    = h_addr[OFS_W-1:2];
  end

  // command / status engine
  cmd_word_t  cmd_q;
  stat_word_t stat_w;
  ipc_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_wr    (h_wr && hit_cmd),
    .cmd_wdata (h_wdata),
    .done      (c_done),
    .done_err  (c_err),
    .done_code (c_err_code),
    .done_init (c_initiator),
    .cmd_q     (cmd_q),
    .cmd_pulse (c_cmd_irq),
    .busy      (c_busy),
    .cpl_irq   (h_irq),
    .overrun   (c_overrun),
    .status    (stat_w)
  );

  assign c_opcode = cmd_q.opcode;
  assign c_ioc    = cmd_q.ioc;
  assign c_sub    = cmd_q.sub;
  assign c_size   = cmd_q.size;

  // outgoing data buffer: host writes, controller reads
  ipc_word_buf #(.NWORDS(NW), .WW(32)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (h_wr && hit_wbuf),
    .widx  (h_idx),
    .wdata (h_wdata),
    .ridx  (c_wbuf_idx),
    .rdata (c_wbuf_data)
  );

  // returned data buffer: controller writes, host reads
  logic [31:0] rbuf_word;
  ipc_word_buf #(.NWORDS(NW), .WW(32)) u_rbuf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (c_rbuf_we),
    .widx  (c_rbuf_idx),
    .wdata (c_rbuf_data),
    .ridx  (h_idx),
    .rdata (rbuf_word)
  );

  // host read data: next value and register
  logic [31:0] rd_d, rd_q;
  logic [7:0]  lane;
  always_comb begin
    case (h_addr[1:0])
      2'd0:    lane = rbuf_word[7:0];
      2'd1:    lane = rbuf_word[15:8];
      2'd2:    lane = rbuf_word[23:16];
      default: lane = rbuf_word[31:24];
    endcase
    rd_d = '0;
    if (hit_cmd) begin
      rd_d = stat_w;
    end else if (hit_rbuf) begin
      rd_d = h_byte ? {24'b0, lane} : rbuf_word;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_q <= '0;
    end else if (h_rd) begin
      rd_q <= rd_d;
    end
  end

  assign h_rdata = rd_q;

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_wr,
  input logic [7:0]  h_addr,
  input logic        h_irq,
  input logic        c_cmd_irq,
  input logic        c_busy,
  input logic        c_overrun,
  input logic        c_done,
  input logic [7:0]  c_opcode,
  input logic [31:0] stat
);

  logic cmd_wr_busy;
  assign cmd_wr_busy = h_wr && (h_addr == 8'h00) && c_busy;

  assert_cmd_pulse_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_cmd_irq |=> !c_cmd_irq);

  assert_pulse_with_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_cmd_irq |-> (c_busy && !$past(c_busy)));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_busy |=> c_overrun);

  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_overrun |=> c_overrun);

  assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_busy && !c_done) |=> (c_busy && !c_cmd_irq && $stable(c_opcode)));

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && c_busy) |=> !c_busy);

  assert_irq_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> $fell(c_busy));

  assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |=> !h_irq);

  assert_idle_done_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && !c_busy) |=> ($stable(stat[31:1]) && !h_irq));

endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .h_wr      (h_wr),
  .h_addr    (h_addr),
  .h_irq     (h_irq),
  .c_cmd_irq (c_cmd_irq),
  .c_busy    (c_busy),
  .c_overrun (c_overrun),
  .c_done    (c_done),
  .c_opcode  (c_opcode),
  .stat      (stat_w)
);

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_wr, h_rd, h_byte;
  logic [7:0]  h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic        h_irq, c_cmd_irq, c_ioc, c_busy, c_overrun;
  logic [7:0]  c_opcode, c_size;
  logic [3:0]  c_sub;
  logic [1:0]  c_wbuf_idx, c_rbuf_idx;
  logic [31:0] c_wbuf_data, c_rbuf_data;
  logic        c_rbuf_we, c_done, c_err;
  logic [7:0]  c_err_code, c_initiator;

  always #4 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_byte(h_byte),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_cmd_irq(c_cmd_irq), .c_opcode(c_opcode), .c_ioc(c_ioc), .c_sub(c_sub),
    .c_size(c_size), .c_busy(c_busy), .c_overrun(c_overrun),
    .c_wbuf_idx(c_wbuf_idx), .c_wbuf_data(c_wbuf_data), .c_rbuf_we(c_rbuf_we),
    .c_rbuf_idx(c_rbuf_idx), .c_rbuf_data(c_rbuf_data), .c_done(c_done),
    .c_err(c_err), .c_err_code(c_err_code), .c_initiator(c_initiator)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    tick();
    h_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, input logic byte_rd, output logic [31:0] d);
    h_rd = 1'b1; h_addr = a; h_byte = byte_rd;
    tick();
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic complete(input logic e, input logic [7:0] code, input logic [7:0] ini);
    c_done = 1'b1; c_err = e; c_err_code = code; c_initiator = ini;
    tick();
    c_done = 1'b0;
  endtask

  function automatic logic [31:0] exp_stat(input logic b, input logic e,
      input logic [3:0] s, input logic [7:0] ini, input logic [7:0] code);
    return {8'h00, code, ini, s, 2'b00, e, b};
  endfunction

  // {command word, initiator, error code, error flag}
  localparam logic [55:0] VEC [4] = '{
    {32'h0004_1123, 8'h5A, 8'h00, 8'h00},
    {32'h0010_F0FF, 8'hA5, 8'h7E, 8'h01},
    {32'hFF08_8E41, 8'h01, 8'hC3, 8'h01},
    {32'h0000_7300, 8'hFF, 8'hFF, 8'h00}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cw;
    h_wr = 0; h_rd = 0; h_byte = 0; h_addr = 0; h_wdata = 0;
    c_wbuf_idx = 0; c_rbuf_we = 0; c_rbuf_idx = 0; c_rbuf_data = 0;
    c_done = 0; c_err = 0; c_err_code = 0; c_initiator = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 busy in reset", {31'b0, c_busy}, 32'h0);
    chk("R1 irqs in reset", {30'b0, h_irq, c_cmd_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    hread(8'h00, 1'b0, rd);
    chk("R1 status after reset", rd, 32'h0);
    chk("R1 overrun after reset", {31'b0, c_overrun}, 32'h0);
    c_wbuf_idx = 2'd3; #1;
    chk("R1 write buffer zero", c_wbuf_data, 32'h0);
    hread(8'h94, 1'b0, rd);
    chk("R1 read buffer zero", rd, 32'h0);

    // table-driven command/complete transactions
    for (int i = 0; i < 4; i++) begin
      logic [7:0] ini, code;
      logic       e;
      cw = VEC[i][55:24]; ini = VEC[i][23:16]; code = VEC[i][15:8]; e = VEC[i][0];
      hwrite(8'h00, cw);
      chk("R2 pulse", {31'b0, c_cmd_irq}, 32'h1);
      chk("R2 busy set", {31'b0, c_busy}, 32'h1);
      chk("R2 opcode", {24'b0, c_opcode}, {24'b0, cw[7:0]});
      chk("R2 ioc", {31'b0, c_ioc}, {31'b0, cw[8]});
      chk("R2 sub", {28'b0, c_sub}, {28'b0, cw[15:12]});
      chk("R2 size", {24'b0, c_size}, {24'b0, cw[23:16]});
      hread(8'h00, 1'b0, rd);
      chk("R2 pulse one cycle", {31'b0, c_cmd_irq}, 32'h0);
      chk("R4 status busy poll", {31'b0, rd[0]}, 32'h1);
      complete(e, code, ini);
      chk("R4 busy cleared", {31'b0, c_busy}, 32'h0);
      chk("R5 host irq", {31'b0, h_irq}, {31'b0, cw[8]});
      hread(8'h00, 1'b0, rd);
      chk("R5 host irq one cycle", {31'b0, h_irq}, 32'h0);
      chk("R4 status word", rd, exp_stat(1'b0, e, cw[15:12], ini, code));
    end

    // overrun: second command while busy
    hwrite(8'h00, 32'h0002_5166);
    hwrite(8'h00, 32'h0009_A1EE);
    chk("R3 no pulse while busy", {31'b0, c_cmd_irq}, 32'h0);
    chk("R3 opcode kept", {24'b0, c_opcode}, 32'h66);
    chk("R3 sub kept", {28'b0, c_sub}, 32'h5);
    chk("R3 overrun set", {31'b0, c_overrun}, 32'h1);
    complete(1'b0, 8'h12, 8'h34);
    chk("R5 irq for ioc cmd", {31'b0, h_irq}, 32'h1);
    tick();
    chk("R3 overrun sticky", {31'b0, c_overrun}, 32'h1);
    hread(8'h00, 1'b0, rd);
    chk("R4 status after overrun", rd, exp_stat(1'b0, 1'b0, 4'h5, 8'h34, 8'h12));

    // completion while idle
    complete(1'b1, 8'hEE, 8'hDD);
    chk("R6 no irq when idle", {31'b0, h_irq}, 32'h0);
    hread(8'h00, 1'b0, rd);
    chk("R6 status unchanged", rd, exp_stat(1'b0, 1'b0, 4'h5, 8'h34, 8'h12));

    // write buffer
    for (int w = 0; w < 4; w++) hwrite(8'h80 + 8'(4*w), 32'hC0DE_0000 + 32'(w * 17));
    for (int w = 0; w < 4; w++) begin
      c_wbuf_idx = 2'(w); #1;
      chk("R7 controller reads word", c_wbuf_data, 32'hC0DE_0000 + 32'(w * 17));
    end
    hread(8'h88, 1'b0, rd);
    chk("R7 host read of write buffer", rd, 32'h0);

    // read buffer
    for (int w = 0; w < 4; w++) begin
      c_rbuf_we = 1'b1; c_rbuf_idx = 2'(w); c_rbuf_data = {4{8'(8'h10 * w + 1)}} + 32'h0302_0100;
      tick();
    end
    c_rbuf_we = 1'b0;
    hread(8'h98, 1'b0, rd);
    chk("R8 word read", rd, 32'h2423_2221);
    hread(8'h9B, 1'b1, rd);
    chk("R8 byte lane 3", rd, 32'h24);
    hread(8'h95, 1'b1, rd);
    chk("R8 byte lane 1", rd, 32'h12);
    hread(8'h90, 1'b1, rd);
    chk("R8 byte lane 0", rd, 32'h01);
    hwrite(8'h9C, 32'hFFFF_FFFF);
    hread(8'h9C, 1'b0, rd);
    chk("R9 read buffer write ignored", rd, 32'h3433_3231);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule